// File: doc/BRIEF.md
# Exception Entry Bus Sequencer

This block drives the bus activity a CPU with a 16-bit data bus goes through when it begins exception processing. A one-cycle request carries a type (reset, interrupt or trap), a vector address, the return program counter, the stack pointer and an extended status byte. The block then runs a fixed list of word cycles. Interrupts and traps push the return state onto a stack that grows downward. Every type then reads a 32-bit handler address from two vector words and performs the first instruction fetch at that address.

Each bus cycle is either a read, a write or an internal cycle. A read or write holds its address and controls until ready is sampled high. An internal cycle takes exactly one clock and does not use the ready handshake. A done pulse reports that the handler fetch has finished. The handler address and the updated stack pointer stay on outputs until the next request.

Top module: `exc_entry_seq`

## Requirements
- R1: `type_i` encodes reset as 0 and interrupt as 1; the values 2 and 3 select trap. A reset request produces exactly these cycles: a read at the vector address, a read at vector+2, one internal cycle, and a read at the handler address. No writes occur and `sp_o` ends equal to `sp_i`.
- R2: An interrupt request produces these cycles in order: a read at pc+2, one internal cycle, three stack writes, a read at the vector address, a read at vector+2, one internal cycle, and a read at the handler address.
- R3: A trap request produces a read at pc, then a read at pc+2, then one internal cycle. It then continues with the same writes, vector reads, internal cycle and handler read as R2.
- R4: An interrupt request with `wake_i` high replaces the first read with an internal cycle, so two internal cycles come first. The rest of the sequence is the same as R2.
- R5: Each stack write uses the stack pointer minus 2 as its address and then lowers the stack pointer by 2. The three writes carry pc[15:0], then pc[31:16], then {8'h00, exr}. After interrupt or trap entry, `sp_o` equals `sp_i` - 6.
- R6: The handler address is {first vector word, second vector word}. The final read uses this address, and `handler_o` shows it once done is reported.
- R7: `bus_lock_o` is high only during the read at the vector address, and never during any other cycle.
- R8: While `bus_req_o` is high and `bus_rdy_i` is low, the address, write enable and lock signals do not change.
- R9: An internal cycle shows `bus_int_o` high with `bus_req_o` low for exactly one clock, whatever the state of `bus_rdy_i`.
- R10: `done_o` is high for a single clock, in the clock after the handler read is accepted.
- R11: A non-reset request that arrives while a sequence is running is ignored. It does not change the running sequence and starts no sequence afterwards.
- R12: A reset request that arrives while a sequence is running abandons that sequence. The reset sequence of R1 starts on the next clock.
- R13: After reset the bus is idle: `bus_req_o`, `bus_int_o` and `done_o` are low, and `sp_o` and `handler_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Exception request, one cycle |
| type_i | input | 2 | 0 reset, 1 interrupt, 2/3 trap |
| wake_i | input | 1 | Interrupt is waking the CPU from a low-power mode |
| vec_addr_i | input | 32 | Vector address |
| pc_i | input | 32 | Return program counter to push |
| exr_i | input | 8 | Extended status byte to push |
| sp_i | input | 32 | Stack pointer at request |
| bus_req_o | output | 1 | Read or write cycle active |
| bus_int_o | output | 1 | Internal cycle, one clock |
| bus_we_o | output | 1 | Write cycle |
| bus_lock_o | output | 1 | Bus locked for this read |
| bus_addr_o | output | 32 | Byte address of the word |
| bus_wdata_o | output | 16 | Write data |
| bus_rdata_i | input | 16 | Read data |
| bus_rdy_i | input | 1 | Cycle accepted when high |
| handler_o | output | 32 | Assembled handler address |
| sp_o | output | 32 | Stack pointer after entry |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Handler fetch complete pulse |

## Verification
The hardest case to reach is a reset request arriving in the middle of a sequence that is already running. To get there, the bench holds ready low so that an interrupt's first read is frozen on the bus. It checks that this read stays stable, then issues reset and releases ready. The scoreboard must then see only the reset cycles, with no leftover interrupt cycle. A second hard case is a request ignored while the block is busy. After done, the bench watches the bus for a long quiet period so that any sequence started late would appear as an unexpected cycle.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  typedef enum logic [1:0] {
    KIND_RESET = 2'd0,
    KIND_IRQ   = 2'd1,
    KIND_TRAP  = 2'd2
  } kind_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PF0, ST_PF1, ST_INT0,
    ST_PUSH_L, ST_PUSH_H, ST_PUSH_X,
    ST_VEC_H, ST_VEC_L, ST_INT1, ST_FETCH
  } step_t;

  function automatic kind_t decode_kind(input logic [1:0] t);
    case (t)
      2'd0:    return KIND_RESET;
      2'd1:    return KIND_IRQ;
      default: return KIND_TRAP;
    endcase
  endfunction
endpackage

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
  import exc_seq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  req_i,
  input  kind_t kind_i,
  input  logic  wake_i,
  input  logic  rdy_i,
  output step_t step_o,
  output kind_t kind_o,
  output logic  pf_int_o,
  output logic  start_o,
  output logic  done_o
);
  step_t step_q, step_d;
  kind_t kind_q;
  logic  wake_q, done_q, accept;

  // reset preempts anything; other kinds only from idle
  assign accept   = req_i && (step_q == ST_IDLE || kind_i == KIND_RESET);
  assign pf_int_o = (step_q == ST_PF0) && (kind_q == KIND_IRQ) && wake_q;

  always_comb begin
    step_d = step_q;
    if (accept) begin
      step_d = (kind_i == KIND_RESET) ? ST_VEC_H : ST_PF0;
    end else begin
      case (step_q)
        ST_PF0:    if (pf_int_o || rdy_i) step_d = (kind_q == KIND_TRAP) ? ST_PF1 : ST_INT0;
        ST_PF1:    if (rdy_i) step_d = ST_INT0;
        ST_INT0:   step_d = ST_PUSH_L;
        ST_PUSH_L: if (rdy_i) step_d = ST_PUSH_H;
        ST_PUSH_H: if (rdy_i) step_d = ST_PUSH_X;
        ST_PUSH_X: if (rdy_i) step_d = ST_VEC_H;
        ST_VEC_H:  if (rdy_i) step_d = ST_VEC_L;
        ST_VEC_L:  if (rdy_i) step_d = ST_INT1;
        ST_INT1:   step_d = ST_FETCH;
        ST_FETCH:  if (rdy_i) step_d = ST_IDLE;
        default:   step_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= ST_IDLE;
      kind_q <= KIND_RESET;
      wake_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      step_q <= step_d;
      done_q <= (step_q == ST_FETCH) && rdy_i && !accept;
      if (accept) begin
        kind_q <= kind_i;
        wake_q <= wake_i && (kind_i == KIND_IRQ);
      end
    end
  end

  assign step_o  = step_q;
  assign kind_o  = kind_q;
  assign start_o = accept;
  assign done_o  = done_q;
endmodule

// File: rtl/exc_ctx_regs.sv
module exc_ctx_regs
  import exc_seq_pkg::*;
#(
  parameter int DW = 16,
  parameter int XW = 8,
  localparam int AW = 2 * DW,
  localparam int WB = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  step_t         step_i,
  input  logic          rdy_i,
  input  logic [AW-1:0] pc_i,
  input  logic [XW-1:0] exr_i,
  input  logic [AW-1:0] vec_i,
  input  logic [AW-1:0] sp_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] pc_o,
  output logic [XW-1:0] exr_o,
  output logic [AW-1:0] vec_o,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] handler_o
);
  logic is_push;
  assign is_push = (step_i == ST_PUSH_L) || (step_i == ST_PUSH_H) || (step_i == ST_PUSH_X);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o      <= '0;
      exr_o     <= '0;
      vec_o     <= '0;
      sp_o      <= '0;
      handler_o <= '0;
    end else if (start_i) begin
      pc_o  <= pc_i;
      exr_o <= exr_i;
      vec_o <= vec_i;
      sp_o  <= sp_i;
    end else if (rdy_i) begin
      if (is_push) sp_o <= sp_o - AW'(WB);
      if (step_i == ST_VEC_H) handler_o[AW-1:DW] <= rdata_i;
      if (step_i == ST_VEC_L) handler_o[DW-1:0]  <= rdata_i;
    end
  end
endmodule

// File: rtl/exc_bus_drv.sv
module exc_bus_drv
  import exc_seq_pkg::*;
#(
  parameter int DW = 16,
  parameter int XW = 8,
  localparam int AW = 2 * DW,
  localparam int WB = DW / 8
) (
  input  step_t         step_i,
  input  kind_t         kind_i,
  input  logic          pf_int_i,
  input  logic [AW-1:0] pc_i,
  input  logic [XW-1:0] exr_i,
  input  logic [AW-1:0] vec_i,
  input  logic [AW-1:0] sp_i,
  input  logic [AW-1:0] handler_i,
  output logic          req_o,
  output logic          int_o,
  output logic          we_o,
  output logic          lock_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o
);
  always_comb begin
    req_o   = 1'b0;
    int_o   = 1'b0;
    we_o    = 1'b0;
    lock_o  = 1'b0;
    addr_o  = '0;
    wdata_o = '0;
    case (step_i)
      ST_PF0: begin
        if (pf_int_i) int_o = 1'b1;
        else begin
          req_o  = 1'b1;
          addr_o = (kind_i == KIND_TRAP) ? pc_i : pc_i + AW'(WB);
        end
      end
      ST_PF1: begin
        req_o  = 1'b1;
        addr_o = pc_i + AW'(WB);
      end
      ST_INT0, ST_INT1: int_o = 1'b1;
      ST_PUSH_L, ST_PUSH_H, ST_PUSH_X: begin
        req_o  = 1'b1;
        we_o   = 1'b1;
        addr_o = sp_i - AW'(WB);
        case (step_i)
          ST_PUSH_L: wdata_o = pc_i[DW-1:0];
          ST_PUSH_H: wdata_o = pc_i[AW-1:DW];
          default:   wdata_o = DW'(exr_i);
        endcase
      end
      ST_VEC_H: begin
        req_o  = 1'b1;
        lock_o = 1'b1;
        addr_o = vec_i;
      end
      ST_VEC_L: begin
        req_o  = 1'b1;
        addr_o = vec_i + AW'(WB);
      end
      ST_FETCH: begin
        req_o  = 1'b1;
        addr_o = handler_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int DW = 16,
  parameter int XW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [1:0]    type_i,
  input  logic          wake_i,
  input  logic [AW-1:0] vec_addr_i,
  input  logic [AW-1:0] pc_i,
  input  logic [XW-1:0] exr_i,
  input  logic [AW-1:0] sp_i,
  output logic          bus_req_o,
  output logic          bus_int_o,
  output logic          bus_we_o,
  output logic          bus_lock_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_rdy_i,
  output logic [AW-1:0] handler_o,
  output logic [AW-1:0] sp_o,
  output logic          busy_o,
  output logic          done_o
);
  step_t         step;
  kind_t         kind;
  logic          pf_int, start;
  logic [AW-1:0] pc_q, vec_q, sp_q, hand_q;
  logic [XW-1:0] exr_q;

  exc_seq_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .kind_i   (decode_kind(type_i)),
    .wake_i   (wake_i),
    .rdy_i    (bus_rdy_i),
    .step_o   (step),
    .kind_o   (kind),
    .pf_int_o (pf_int),
    .start_o  (start),
    .done_o   (done_o)
  );

  exc_ctx_regs #(.DW(DW), .XW(XW)) u_ctx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .step_i    (step),
    .rdy_i     (bus_rdy_i),
    .pc_i      (pc_i),
    .exr_i     (exr_i),
    .vec_i     (vec_addr_i),
    .sp_i      (sp_i),
    .rdata_i   (bus_rdata_i),
    .pc_o      (pc_q),
    .exr_o     (exr_q),
    .vec_o     (vec_q),
    .sp_o      (sp_q),
    .handler_o (hand_q)
  );

  exc_bus_drv #(.DW(DW), .XW(XW)) u_drv (
    .step_i    (step),
    .kind_i    (kind),
    .pf_int_i  (pf_int),
    .pc_i      (pc_q),
    .exr_i     (exr_q),
    .vec_i     (vec_q),
    .sp_i      (sp_q),
    .handler_i (hand_q),
    .req_o     (bus_req_o),
    .int_o     (bus_int_o),
    .we_o      (bus_we_o),
    .lock_o    (bus_lock_o),
    .addr_o    (bus_addr_o),
    .wdata_o   (bus_wdata_o)
  );

  assign handler_o = hand_q;
  assign sp_o      = sp_q;
  assign busy_o    = (step != ST_IDLE);
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic [1:0]    type_i,
  input logic          bus_req_o,
  input logic          bus_int_o,
  input logic          bus_we_o,
  input logic          bus_lock_o,
  input logic [AW-1:0] bus_addr_o,
  input logic          bus_rdy_i,
  input logic          done_o
);
  logic rst_req;
  assign rst_req = req_i && (type_i == 2'd0);

  // R7
  lock_on_read_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_lock_o |-> bus_req_o && !bus_we_o);

  // R8
  held_while_waiting_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_rdy_i && !rst_req) |=>
      (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o) && $stable(bus_lock_o)));

  // R9
  internal_no_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_int_o |-> !bus_req_o);

  // R10
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  done_after_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(bus_req_o && bus_rdy_i && !bus_we_o));
endmodule

bind exc_entry_seq exc_entry_seq_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .type_i     (type_i),
  .bus_req_o  (bus_req_o),
  .bus_int_o  (bus_int_o),
  .bus_we_o   (bus_we_o),
  .bus_lock_o (bus_lock_o),
  .bus_addr_o (bus_addr_o),
  .bus_rdy_i  (bus_rdy_i),
  .done_o     (done_o)
);

// File: tb/exc_entry_seq_test.sv
module exc_entry_seq_test;
  localparam int K_RD = 0, K_WR = 1, K_IN = 2;

  typedef struct {
    int          kind;
    bit          lock;
    logic [31:0] addr;
    logic [15:0] wdata;
    string       tag;
  } item_t;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, wake = 1'b0, rdy = 1'b0;
  logic [1:0]  typ = 2'd0;
  logic [31:0] vec = '0, pc = '0, sp = '0;
  logic [7:0]  exr = '0;
  logic        bus_req, bus_int, bus_we, bus_lock, busy, done;
  logic [31:0] bus_addr, handler, sp_out;
  logic [15:0] bus_wdata, bus_rdata;

  logic [31:0] cur_vec = '0, cur_hand = '0;
  bit          hold_rdy = 1'b0;
  int          checks = 0, fails = 0;
  item_t       q[$];

  always #10 clk = ~clk;

  exc_entry_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .type_i(typ), .wake_i(wake),
    .vec_addr_i(vec), .pc_i(pc), .exr_i(exr), .sp_i(sp),
    .bus_req_o(bus_req), .bus_int_o(bus_int), .bus_we_o(bus_we), .bus_lock_o(bus_lock),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata),
    .bus_rdy_i(rdy), .handler_o(handler), .sp_o(sp_out), .busy_o(busy), .done_o(done)
  );

  // memory model: vector words return the planned handler
  always_comb begin
    if (bus_addr == cur_vec)           bus_rdata = cur_hand[31:16];
    else if (bus_addr == cur_vec + 2)  bus_rdata = cur_hand[15:0];
    else                               bus_rdata = bus_addr[15:0] ^ 16'hA5C3;
  end

  // ready pattern with wait states
  initial begin
    int c = 0;
    forever begin
      @(posedge clk);
      #1;
      rdy = hold_rdy ? 1'b0 : ((c % 4) != 2);
      c++;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic push(input int k, input bit lk, input logic [31:0] a,
                      input logic [15:0] d, input string tag);
    item_t it;
    it.kind = k; it.lock = lk; it.addr = a; it.wdata = d; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compare each accepted or internal cycle with the scoreboard
  always @(negedge clk) begin
    if (rst_n && ((bus_req && rdy) || bus_int)) begin
      int k;
      k = bus_int ? K_IN : (bus_we ? K_WR : K_RD);
      if (q.size() == 0) begin
        check(1'b0, "R11", "unexpected cycle addr", bus_addr, 32'h0);
      end else begin
        item_t e;
        e = q.pop_front();
        check(k == e.kind, e.tag, "cycle kind", 32'(k), 32'(e.kind));
        check(bus_lock == e.lock, "R7", "lock", 32'(bus_lock), 32'(e.lock));
        if (k != K_IN) check(bus_addr == e.addr, e.tag, "address", bus_addr, e.addr);
        if (k == K_WR) check(bus_wdata == e.wdata, "R5", "write data", 32'(bus_wdata), 32'(e.wdata));
      end
    end
  end

  // push the cycles the requirements call for
  task automatic plan_entry(input logic [1:0] t, input bit wk, input logic [31:0] p,
                            input logic [7:0] x, input logic [31:0] v,
                            input logic [31:0] s, input logic [31:0] h);
    cur_vec  = v;
    cur_hand = h;
    if (t != 2'd0) begin
      if (t == 2'd1) begin
        if (wk) push(K_IN, 0, 0, 0, "R4");           // R4 prefetch replaced
        else    push(K_RD, 0, p + 2, 0, "R2");       // R2 prefetch at pc+2
      end else begin
        push(K_RD, 0, p, 0, "R3");                   // R3 instruction fetch
        push(K_RD, 0, p + 2, 0, "R3");
      end
      push(K_IN, 0, 0, 0, "R9");
      push(K_WR, 0, s - 2, p[15:0], "R5");
      push(K_WR, 0, s - 4, p[31:16], "R5");
      push(K_WR, 0, s - 6, {8'h00, x}, "R5");
    end
    push(K_RD, 1, v, 0, "R1");                       // R1/R7 locked vector read
    push(K_RD, 0, v + 2, 0, "R1");
    push(K_IN, 0, 0, 0, "R9");
    push(K_RD, 0, h, 0, "R6");                       // R6 handler fetch
  endtask

  task automatic fire(input logic [1:0] t, input bit wk, input logic [31:0] p,
                      input logic [7:0] x, input logic [31:0] v, input logic [31:0] s);
    @(negedge clk);
    req = 1'b1; typ = t; wake = wk; pc = p; exr = x; vec = v; sp = s;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_done(input logic [31:0] h, input logic [31:0] s, input string tag);
    int n = 0;
    while (!done && n < 500) begin
      @(negedge clk);
      n++;
    end
    check(done == 1'b1, "R10", "done seen", 32'(done), 32'h1);
    check(handler == h, "R6", "handler_o", handler, h);
    check(sp_out == s, tag, "sp_o", sp_out, s);
    check(q.size() == 0, tag, "cycles left", 32'(q.size()), 32'h0);
    @(negedge clk);
    check(done == 1'b0, "R10", "done single", 32'(done), 32'h0);
  endtask

  initial begin
    #3_000_000;
    check(1'b0, "WDOG", "watchdog expired", 32'h0, 32'h1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    check(bus_req == 0 && bus_int == 0 && done == 0, "R13", "bus idle",
          {29'h0, bus_req, bus_int, done}, 32'h0);
    check(sp_out == 0 && handler == 0, "R13", "outputs zero", sp_out | handler, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset entry, no pushes
    plan_entry(2'd0, 0, 32'h0, 8'h0, 32'h0000_0000, 32'h0000_FF00, 32'h0000_1234);
    fire(2'd0, 0, 32'h0, 8'h0, 32'h0000_0000, 32'h0000_FF00);
    wait_done(32'h0000_1234, 32'h0000_FF00, "R1");

    // R2 interrupt entry
    plan_entry(2'd1, 0, 32'h0012_3456, 8'h87, 32'h0000_0040, 32'h00FF_FF00, 32'h0000_8000);
    fire(2'd1, 0, 32'h0012_3456, 8'h87, 32'h0000_0040, 32'h00FF_FF00);
    wait_done(32'h0000_8000, 32'h00FF_FEFA, "R5");

    // R4 interrupt on wake
    plan_entry(2'd1, 1, 32'h00AB_0010, 8'h03, 32'h0000_0080, 32'h0001_0000, 32'hDEAD_BEE0);
    fire(2'd1, 1, 32'h00AB_0010, 8'h03, 32'h0000_0080, 32'h0001_0000);
    wait_done(32'hDEAD_BEE0, 32'h0000_FFFA, "R4");

    // R3 trap, type value 3 also trap
    plan_entry(2'd3, 0, 32'h0000_2000, 8'h41, 32'h0000_0020, 32'h0000_4000, 32'h0055_AA00);
    fire(2'd3, 0, 32'h0000_2000, 8'h41, 32'h0000_0020, 32'h0000_4000);
    wait_done(32'h0055_AA00, 32'h0000_3FFA, "R3");

    // R11 requests while busy are ignored
    plan_entry(2'd2, 0, 32'h0000_3000, 8'h10, 32'h0000_0030, 32'h0000_5000, 32'h0000_6000);
    fire(2'd2, 0, 32'h0000_3000, 8'h10, 32'h0000_0030, 32'h0000_5000);
    repeat (3) @(negedge clk);
    fire(2'd1, 1, 32'h0077_7777, 8'hFF, 32'h0000_0030, 32'h0000_9000);
    wait_done(32'h0000_6000, 32'h0000_4FFA, "R11");
    repeat (30) @(negedge clk);
    check(busy == 1'b0 && q.size() == 0, "R11", "no late sequence", 32'(busy), 32'h0);

    // R8 stall, then R12 reset abort
    hold_rdy = 1'b1;
    @(negedge clk);
    fire(2'd1, 0, 32'h0000_7000, 8'h22, 32'h0000_0050, 32'h0000_8800);
    check(bus_req == 1'b1 && bus_addr == 32'h0000_7002, "R8", "stalled read addr",
          bus_addr, 32'h0000_7002);
    repeat (3) @(negedge clk);
    check(bus_req == 1'b1 && bus_addr == 32'h0000_7002 && !bus_we, "R8", "held addr",
          bus_addr, 32'h0000_7002);
    plan_entry(2'd0, 0, 32'h0, 8'h0, 32'h0000_0060, 32'h0000_1100, 32'h0000_0ABC);
    @(negedge clk);
    req = 1'b1; typ = 2'd0; wake = 0; vec = 32'h0000_0060; sp = 32'h0000_1100;
    hold_rdy = 1'b0;
    @(negedge clk);
    req = 1'b0;
    check(bus_lock == 1'b1 && bus_addr == 32'h0000_0060, "R12", "restart at vector",
          bus_addr, 32'h0000_0060);
    wait_done(32'h0000_0ABC, 32'h0000_1100, "R12");

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule